// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block is a register-mapped mailbox between a host CPU and a secure coprocessor. The host fills a bank of sixteen 32-bit argument registers and then writes a command word. That one write bundles the command and the current argument values into a frame and places it in a four-entry queue. Writing arguments without a command submits nothing, so the host may build the next frame while earlier ones are still waiting.

The coprocessor sees the oldest frame on a valid/command/arguments port. It removes the frame with a one-cycle pop. Later it reports the outcome with a one-cycle done strobe. The strobe loads a return word and sixteen status words into a result bank, and in the same edge it sets the completion cause. The result therefore becomes readable in the same cycle the cause appears.

Three sticky causes are kept: completion, an attempted command write while the queue was full, and queue full. Writing ones to the cause register clears them. A mask register gates each cause onto a level interrupt output. The host reads the queue depth and a coprocessor-ready flag from a status word.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the queue is empty (`cop_valid` low, status bits [2:0] = 0), the cause register (word offset 0xC8) reads 0, the mask register (0xCC) reads 0x0006_0001 and `irq` is low.
- R2: Writes to the argument registers (0x00..0x3C, argument i at 0x00 + 4*i) read back, and they never change the queue depth or `cop_valid`.
- R3: A write to the command register (0x40) while fewer than 4 frames are pending appends a frame: the written command, plus the argument registers as they stood at that write (argument i on `cop_args[32*i +: 32]`). The depth in status bits [2:0] rises by one.
- R4: Frames leave in the order they were written. A one-cycle `cop_pop` removes the head, and the next frame then appears on `cop_cmd`/`cop_args`.
- R5: A command write while 4 frames are pending is dropped. The depth stays 4 and cause bits 17 and 18 are both set.
- R6: A `cop_done` strobe loads `cop_retval` into the word at 0x80 and status word i into 0x84 + 4*i. In the same edge it sets cause bit 0.
- R7: Writing the cause register clears exactly the bits written as one. Cause bits that are set by an event in the same cycle stay set.
- R8: `irq` is high exactly when some cause bit is set and its mask bit is 0. Changing the mask never changes the cause bits.
- R9: Status bit 8 (0xC4) follows the `cop_ready` input.
- R10: Reads of the command register, of unmapped word offsets, and of unimplemented bits in the cause and mask registers return zero.
- R11: A `cop_pop` while the queue is empty has no effect.
- R12: Only mask bits 0, 17 and 18 are writable. All other mask bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| cop_ready | input | 1 | Coprocessor ready indication |
| cop_valid | output | 1 | A frame is pending at the head |
| cop_cmd | output | 32 | Head frame command |
| cop_args | output | 512 | Head frame arguments, argument i at [32*i +: 32] |
| cop_pop | input | 1 | Remove head frame (one cycle) |
| cop_done | input | 1 | Completion strobe (one cycle) |
| cop_retval | input | 32 | Return word loaded on cop_done |
| cop_status | input | 512 | Status words loaded on cop_done, word i at [32*i +: 32] |
| irq | output | 1 | Level interrupt |

## Verification
The queue is filled with four frames whose arguments follow different patterns: ascending counts, walking ones, inverted data, and all-ones with a tagged word. A frame that mixed in arguments from the wrong slot, or that took its arguments from after the command write, therefore shows a wrong value at pop time. A fifth command aimed at the full queue separates a dropped write from an overwrite. The later pops show that no frame was damaged. The interrupt path is driven by flipping the mask while causes stay pending. This tells apart gating by the mask from clearing by the mask. Selective one-writes to the cause register show that the clear acts bit by bit.

// File: rtl/mbx_pkg.sv
// Package: shared constants of the command mailbox.
// Assumes 32-bit registers and a word-aligned byte address.
package mbx_pkg;
    parameter int unsigned MBX_DATA_W    = 32;
    parameter int unsigned MBX_NUM_WORDS = 16;
    parameter int unsigned MBX_QDEPTH    = 4;
    parameter int unsigned MBX_ADDR_W    = 8;

    // Cause bit positions; software decodes these, so they are fixed.
    localparam int unsigned CAUSE_DONE     = 0;
    localparam int unsigned CAUSE_ACC_FULL = 17;
    localparam int unsigned CAUSE_Q_FULL   = 18;
    localparam int unsigned QSTAT_READY    = 8;

    // Implemented bits of the cause and mask registers.
    localparam logic [MBX_DATA_W-1:0] CAUSE_IMPL =
        (MBX_DATA_W'(1) << CAUSE_DONE) |
        (MBX_DATA_W'(1) << CAUSE_ACC_FULL) |
        (MBX_DATA_W'(1) << CAUSE_Q_FULL);
endpackage

// File: rtl/mbx_cmd_queue.sv
// Module: circular queue of command frames.
// A push when full or a pop when empty is ignored. The head frame is
// presented combinationally. Slot contents have no reset; only the
// pointers and the count do.
module mbx_cmd_queue #(
    parameter int unsigned DEPTH   = 4,
    parameter int unsigned FRAME_W = 544
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [FRAME_W-1:0]           frame_i,
    input  logic                         pop_i,
    output logic [FRAME_W-1:0]           frame_o,
    output logic                         valid_o,
    output logic                         full_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [FRAME_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   count_q;
    logic               do_push, do_pop;

    assign valid_o = (count_q != '0);
    assign full_o  = (count_q == CNT_W'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && valid_o;
    assign frame_o = slots[rd_ptr];
    assign count_o = count_q;

    // Purpose: store an accepted frame in the write slot.
    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= frame_i;
    end

    // Purpose: advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count_q <= count_q + 1'b1;
            else if (do_pop && !do_push) count_q <= count_q - 1'b1;
        end
    end
endmodule

// File: rtl/mbx_result_bank.sv
// Module: holds the return word and status words of the last completion.
// Everything loads in one edge on the done strobe, so all words are
// valid together.
module mbx_result_bank #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_WORDS = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          done_i,
    input  logic [DATA_W-1:0]             retval_i,
    input  logic [NUM_WORDS*DATA_W-1:0]   status_i,
    output logic [DATA_W-1:0]             retval_o,
    output logic [NUM_WORDS*DATA_W-1:0]   status_o
);
    // Purpose: capture the result block on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retval_o <= '0;
            status_o <= '0;
        end else if (done_i) begin
            retval_o <= retval_i;
            status_o <= status_i;
        end
    end
endmodule

// File: rtl/mbx_irq_ctrl.sv
// Module: sticky cause register with write-one-to-clear, mask register,
// and a level interrupt. Only the bits in IMPL exist. The mask resets
// to all-disabled. A set and a clear of the same bit in the same cycle
// leave the bit set.
module mbx_irq_ctrl #(
    parameter int unsigned       DATA_W = 32,
    parameter logic [DATA_W-1:0] IMPL   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_i,
    input  logic              clr_we_i,
    input  logic              mask_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cause_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] clr_bits;

    assign clr_bits = clr_we_i ? wdata_i : '0;
    assign irq_o    = |(cause_o & ~mask_o);

    // Purpose: update the sticky causes; new events win over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_o <= '0;
        else        cause_o <= ((cause_o & ~clr_bits) | set_i) & IMPL;
    end

    // Purpose: hold the mask; reset masks every cause.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_o <= IMPL;
        else if (mask_we_i) mask_o <= wdata_i & IMPL;
    end
endmodule

// File: rtl/cmd_mailbox.sv
// Module: top of the host-to-coprocessor command mailbox.
// Decodes a single-cycle register bus: argument bank, command trigger,
// result words, queue status, cause and mask. Reads are combinational.
// Assumes bus_addr is word aligned.
module cmd_mailbox #(
    parameter int unsigned DATA_W    = mbx_pkg::MBX_DATA_W,
    parameter int unsigned NUM_WORDS = mbx_pkg::MBX_NUM_WORDS,
    parameter int unsigned QDEPTH    = mbx_pkg::MBX_QDEPTH,
    parameter int unsigned ADDR_W    = mbx_pkg::MBX_ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr_en,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic                        cop_ready,
    output logic                        cop_valid,
    output logic [DATA_W-1:0]           cop_cmd,
    output logic [NUM_WORDS*DATA_W-1:0] cop_args,
    input  logic                        cop_pop,
    input  logic                        cop_done,
    input  logic [DATA_W-1:0]           cop_retval,
    input  logic [NUM_WORDS*DATA_W-1:0] cop_status,
    output logic                        irq
);
    import mbx_pkg::*;

    localparam int unsigned WI_W    = ADDR_W - 2;
    localparam int unsigned ARGS_W  = NUM_WORDS * DATA_W;
    localparam int unsigned FRAME_W = ARGS_W + DATA_W;
    localparam int unsigned CNT_W   = $clog2(QDEPTH + 1);
    localparam int unsigned W_CMD   = NUM_WORDS;
    localparam int unsigned W_RET   = 2 * NUM_WORDS;
    localparam int unsigned W_STAT0 = W_RET + 1;
    localparam int unsigned W_QSTAT = W_STAT0 + NUM_WORDS;
    localparam int unsigned W_CAUSE = W_QSTAT + 1;
    localparam int unsigned W_MASK  = W_QSTAT + 2;

    logic [WI_W-1:0]     word_idx;
    logic [ARGS_W-1:0]   arg_q;
    logic                cmd_wr, q_push, q_full;
    logic [FRAME_W-1:0]  head_frame;
    logic [CNT_W-1:0]    q_count;
    logic [DATA_W-1:0]   cause_set, cause_q, mask_q, ret_q, qstat_word;
    logic [ARGS_W-1:0]   stat_q;
    logic                unused_addr_lsb;

    assign word_idx        = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^bus_addr[1:0];
    assign cmd_wr          = bus_wr_en && (word_idx == WI_W'(W_CMD));
    assign q_push          = cmd_wr && !q_full;

    // Argument bank: one register per word, written by address.
    for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_arg
        // Purpose: capture a host write to argument word gi.
        always_ff @(posedge clk) begin
            if (!rst_n)
                arg_q[gi*DATA_W +: DATA_W] <= '0;
            else if (bus_wr_en && word_idx == WI_W'(gi))
                arg_q[gi*DATA_W +: DATA_W] <= bus_wdata;
        end
    end

    mbx_cmd_queue #(.DEPTH(QDEPTH), .FRAME_W(FRAME_W)) queue_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (q_push),
        .frame_i ({bus_wdata, arg_q}),
        .pop_i   (cop_pop),
        .frame_o (head_frame),
        .valid_o (cop_valid),
        .full_o  (q_full),
        .count_o (q_count)
    );

    assign cop_cmd  = head_frame[FRAME_W-1 -: DATA_W];
    assign cop_args = head_frame[ARGS_W-1:0];

    mbx_result_bank #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) result_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (cop_done),
        .retval_i (cop_retval),
        .status_i (cop_status),
        .retval_o (ret_q),
        .status_o (stat_q)
    );

    // Purpose: collect the cause events of this cycle.
    always_comb begin
        cause_set                 = '0;
        cause_set[CAUSE_DONE]     = cop_done;
        cause_set[CAUSE_ACC_FULL] = cmd_wr && q_full;
        cause_set[CAUSE_Q_FULL]   = cmd_wr && q_full;
    end

    mbx_irq_ctrl #(.DATA_W(DATA_W), .IMPL(CAUSE_IMPL)) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (cause_set),
        .clr_we_i  (bus_wr_en && word_idx == WI_W'(W_CAUSE)),
        .mask_we_i (bus_wr_en && word_idx == WI_W'(W_MASK)),
        .wdata_i   (bus_wdata),
        .cause_o   (cause_q),
        .mask_o    (mask_q),
        .irq_o     (irq)
    );

    // Purpose: form the queue-status word (depth low, ready flag).
    always_comb begin
        qstat_word              = '0;
        qstat_word[CNT_W-1:0]   = q_count;
        qstat_word[QSTAT_READY] = cop_ready;
    end

    // Purpose: read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (word_idx == WI_W'(i))           bus_rdata = arg_q[i*DATA_W +: DATA_W];
            if (word_idx == WI_W'(W_STAT0 + i)) bus_rdata = stat_q[i*DATA_W +: DATA_W];
        end
        if (word_idx == WI_W'(W_RET))   bus_rdata = ret_q;
        if (word_idx == WI_W'(W_QSTAT)) bus_rdata = qstat_word;
        if (word_idx == WI_W'(W_CAUSE)) bus_rdata = cause_q;
        if (word_idx == WI_W'(W_MASK))  bus_rdata = mask_q;
    end
endmodule

// File: rtl/mbx_checker.sv
// Module: temporal checks on the mailbox, bound to the top module.
// Observes the bus, the coprocessor port and the queue count.
module mbx_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned QDEPTH = 4,
    parameter int unsigned CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              cop_pop,
    input logic              cop_done,
    input logic              cop_valid,
    input logic              irq,
    input logic [CNT_W-1:0]  q_count,
    input logic [DATA_W-1:0] cause_q
);
    logic arg_wr, cmd_wr;
    assign arg_wr = bus_wr_en && (bus_addr < 8'h40);
    assign cmd_wr = bus_wr_en && (bus_addr == 8'h40);

    // R2: an argument write leaves the depth unchanged.
    assert_arg_no_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arg_wr && !cop_pop) |=> $stable(q_count));

    // R3: an accepted command makes a frame visible.
    assert_cmd_makes_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && q_count < CNT_W'(QDEPTH)) |=> cop_valid);

    // R5: the depth never passes the queue size.
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(QDEPTH));

    // R5: a command aimed at a full queue raises both full causes.
    assert_drop_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && q_count == CNT_W'(QDEPTH)) |=> (cause_q[17] && cause_q[18]));

    // R6: completion raises cause bit 0.
    assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cop_done |=> cause_q[0]);

    // R8: no interrupt without a pending cause.
    assert_irq_needs_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q == '0) |-> !irq);

    // R11: a pop of an empty queue leaves it empty.
    assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cop_valid && cop_pop && !cmd_wr) |=> !cop_valid);
endmodule

bind cmd_mailbox mbx_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .QDEPTH(QDEPTH), .CNT_W(CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .cop_pop   (cop_pop),
    .cop_done  (cop_done),
    .cop_valid (cop_valid),
    .irq       (irq),
    .q_count   (q_count),
    .cause_q   (cause_q)
);

// File: tb/cmd_mailbox_tb_top.sv
`timescale 1ns/100ps
// Bench: scoreboard of submitted frames, compared at the coprocessor port.
module cmd_mailbox_tb_top;
    localparam int NW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          cop_ready = 1'b0;
    logic          cop_valid;
    logic [31:0]   cop_cmd;
    logic [NW*32-1:0] cop_args;
    logic          cop_pop = 1'b0;
    logic          cop_done = 1'b0;
    logic [31:0]   cop_retval = '0;
    logic [NW*32-1:0] cop_status = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    logic [NW*32+31:0] exp_q [$];

    always #2.5 clk = ~clk;

    cmd_mailbox dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cop_ready(cop_ready),
        .cop_valid(cop_valid), .cop_cmd(cop_cmd), .cop_args(cop_args),
        .cop_pop(cop_pop), .cop_done(cop_done), .cop_retval(cop_retval),
        .cop_status(cop_status), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // Driver: load arguments, submit, record the expected frame.
    task automatic send_cmd(input logic [31:0] cmd, input logic [NW*32-1:0] args, input bit expect_ok);
        for (int i = 0; i < NW; i++) bus_write(8'(4*i), args[i*32 +: 32]);
        bus_write(8'h40, cmd);
        if (expect_ok) exp_q.push_back({cmd, args});
    endtask

    // Monitor: compare the head with the scoreboard, then pop it.
    task automatic pop_and_check();
        logic [NW*32+31:0] e;
        e = exp_q.pop_front();
        check("R4 head valid", 32'(cop_valid), 32'd1);
        check("R3/R4 head command", cop_cmd, e[NW*32 +: 32]);
        for (int i = 0; i < NW; i++)
            check("R3/R4 head argument", cop_args[i*32 +: 32], e[i*32 +: 32]);
        @(negedge clk); cop_pop = 1'b1;
        @(negedge clk); cop_pop = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        logic [NW*32-1:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(8'hC4, r); check("R1 depth", r & 32'h7, 0);
        bus_read(8'hC8, r); check("R1 cause", r, 0);
        bus_read(8'hCC, r); check("R1 mask", r, 32'h0006_0001);
        check("R1 irq", 32'(irq), 0);
        check("R1 valid", 32'(cop_valid), 0);

        // R9 ready flag
        cop_ready = 1'b1; bus_read(8'hC4, r); check("R9 ready high", r, 32'h100);
        cop_ready = 1'b0; bus_read(8'hC4, r); check("R9 ready low", r, 0);

        // R2 argument writes only
        for (int i = 0; i < NW; i++) bus_write(8'(4*i), 32'hA000_0000 + 32'(i));
        bus_read(8'h14, r); check("R2 arg readback", r, 32'hA000_0005);
        bus_read(8'hC4, r); check("R2 depth unchanged", r & 32'h7, 0);
        check("R2 valid unchanged", 32'(cop_valid), 0);

        // R3 fill queue with four distinct patterns
        for (int i = 0; i < NW; i++) a[i*32 +: 32] = 32'(i + 1);
        send_cmd(32'h0000_0011, a, 1'b1);
        bus_read(8'hC4, r); check("R3 depth one", r & 32'h7, 1);
        for (int i = 0; i < NW; i++) a[i*32 +: 32] = 32'h1 << i;
        send_cmd(32'h0000_0022, a, 1'b1);
        for (int i = 0; i < NW; i++) a[i*32 +: 32] = ~(32'(i) * 32'h0101_0101);
        send_cmd(32'h0000_0033, a, 1'b1);
        for (int i = 0; i < NW; i++) a[i*32 +: 32] = (i == 7) ? 32'h5A5A_7777 : 32'hFFFF_FFFF;
        send_cmd(32'h0000_0044, a, 1'b1);
        bus_read(8'hC4, r); check("R3 depth four", r & 32'h7, 4);
        bus_read(8'h40, r); check("R10 command reads zero", r, 0);

        // R5 command into full queue is dropped
        bus_write(8'h40, 32'hDEAD_0055);
        bus_read(8'hC4, r); check("R5 depth stays four", r & 32'h7, 4);
        bus_read(8'hC8, r); check("R5 full causes", r, 32'h0006_0000);
        check("R8 masked no irq", 32'(irq), 0);

        // R8 / R12 mask behaviour
        bus_write(8'hCC, 32'h0000_0000);
        check("R8 unmasked irq", 32'(irq), 1);
        bus_write(8'hCC, 32'hFFFF_FFFF);
        bus_read(8'hCC, r); check("R12 mask bits", r, 32'h0006_0001);
        check("R8 remasked irq", 32'(irq), 0);
        bus_read(8'hC8, r); check("R8 cause kept", r, 32'h0006_0000);

        // R7 selective clear
        bus_write(8'hC8, 32'h0002_0000);
        bus_read(8'hC8, r); check("R7 clear bit17 only", r, 32'h0004_0000);
        bus_write(8'hC8, 32'h0004_0000);
        bus_read(8'hC8, r); check("R7 clear bit18", r, 0);

        // R4 drain in order
        for (int k = 0; k < 4; k++) begin
            pop_and_check();
            bus_read(8'hC4, r); check("R4 depth after pop", r & 32'h7, 32'(3 - k));
        end

        // R11 empty pop ignored
        @(negedge clk); cop_pop = 1'b1;
        @(negedge clk); cop_pop = 1'b0;
        bus_read(8'hC4, r); check("R11 depth stays zero", r & 32'h7, 0);
        check("R11 valid stays low", 32'(cop_valid), 0);

        // R6 completion
        cop_retval = 32'hC0DE_0001;
        for (int i = 0; i < NW; i++) cop_status[i*32 +: 32] = 32'h5000_0000 ^ (32'(i) << 4);
        @(negedge clk); cop_done = 1'b1;
        @(negedge clk); cop_done = 1'b0;
        bus_read(8'h80, r); check("R6 return word", r, 32'hC0DE_0001);
        for (int i = 0; i < NW; i++) begin
            bus_read(8'(8'h84 + 4*i), r);
            check("R6 status word", r, 32'h5000_0000 ^ (32'(i) << 4));
        end
        bus_read(8'hC8, r); check("R6 done cause", r, 32'h1);
        bus_write(8'hCC, 32'h0006_0000);
        check("R8 done irq", 32'(irq), 1);
        bus_write(8'hC8, 32'h1);
        check("R7 done cleared irq", 32'(irq), 0);

        // R10 unmapped reads
        bus_read(8'h44, r); check("R10 offset 0x44", r, 0);
        bus_read(8'hD0, r); check("R10 offset 0xD0", r, 0);
        bus_read(8'hFC, r); check("R10 offset 0xFC", r, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule